// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This block holds a small bank of breakpoint slots. Each slot stores a word-aligned instruction address, an enable bit and a four-bit byte-lane mask. Every instruction that the pipeline presents carries the byte address of its first unit and the size of that unit: byte, halfword or word. Each enabled slot compares the word part of that address with its stored value. It then checks that every byte the first unit occupies is selected in the slot's mask.

A slot whose word matches and whose mask covers all required bytes reports a hit. A slot whose word matches and whose mask selects only some of the required bytes is in an unpredictable case. Such a slot reports no hit and raises a separate partial flag. Software loads the slots through a simple write port.

Results are registered. They appear one clock after the instruction strobe, as a per-slot vector and as a combined bit. A 32-bit instruction that starts halfway into a word can be caught with two slots. The bench presents that instruction as two halfwords: one slot masks the upper half of the first word, the other masks the lower half of the next word.

Top module: `ibp_comparator`

## Requirements
- R1: During reset all outputs are zero and every slot is left disabled, so no instruction hits until a slot is programmed.
- R2: A write with `wr_sel`=0 loads the slot's compare address from `wr_data[ADDR_W-1:2]`, ignoring `wr_data[1:0]`. A write with `wr_sel`=1 loads the enable from `wr_data[0]` and the lane mask from `wr_data[8:5]`, where mask bit k selects byte offset k in the word. A write takes effect from the next clock, so an instruction presented in the same cycle is compared against the old contents.
- R3: The required lanes are derived from `ins_size` and `ins_addr[1:0]`. Size 2'b00 (byte) needs only lane `ins_addr[1:0]`. Size 2'b01 (halfword) needs lanes 0 and 1 when `ins_addr[1]`=0 and lanes 2 and 3 when it is 1; `ins_addr[0]` is ignored. Size 2'b10 (word) and the reserved code 2'b11 need all four lanes.
- R4: The address compare uses `ins_addr[ADDR_W-1:2]` only. A difference in any of those bits, however far up, prevents a match.
- R5: An enabled slot whose address matches and whose mask contains every required lane sets its bit in `hit_vec`.
- R6: An enabled slot whose address matches and whose mask selects some but not all required lanes sets its bit in `part_vec` and not in `hit_vec`. No slot ever has both bits set.
- R7: A disabled slot sets neither bit. Neither does a slot whose mask has no lane in common with the required lanes.
- R8: `hit_vec`, `part_vec` and the combined bits show the instruction presented on the previous clock when `ins_valid` was high, and are all zero after a clock with `ins_valid` low.
- R9: `hit_any` is the OR of `hit_vec`, and `part_any` is the OR of `part_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | $clog2(NUM_PAIRS) | Slot selected for the write |
| wr_sel | input | 1 | 0 writes the compare address, 1 writes the control word |
| wr_data | input | 32 | Write data |
| ins_valid | input | 1 | Instruction strobe |
| ins_addr | input | ADDR_W | Byte address of the instruction's first unit |
| ins_size | input | 2 | First-unit size: 00 byte, 01 halfword, 10 word, 11 treated as word |
| hit_vec | output | NUM_PAIRS | Per-slot hit, registered |
| hit_any | output | 1 | OR of all slot hits |
| part_vec | output | NUM_PAIRS | Per-slot partial-coverage flag, registered |
| part_any | output | 1 | OR of all partial flags |

## Verification
The bench uses the default four slots and a 32-bit address. With four slots it can give every mask shape its own slot at once: a single byte, each half of the word, and the full word. One instruction can therefore show a hit in one slot, a partial in another and silence in a third. The full 32-bit width lets the bench change an address bit far above the word offset. It also leaves spare slots for reprogramming, which covers the two-slot catch of a halfword-offset 32-bit instruction and a write colliding with a compare.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } unit_size_e;

    typedef logic [3:0] lane_mask_t;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MASK_LSB = 5;
    localparam int LANES         = 4;

endpackage

// File: rtl/ibp_lane_decode.sv
module ibp_lane_decode
    import ibp_pkg::*;
(
    input  logic [1:0]  offset,
    input  logic [1:0]  size,
    output lane_mask_t  need
);

    always_comb begin
        unique case (unit_size_e'(size))
            SZ_BYTE: need = lane_mask_t'(4'b0001 << offset);
            SZ_HALF: need = offset[1] ? 4'b1100 : 4'b0011;
            default: need = 4'b1111;
        endcase
    end

    // R3
    always_comb begin
        if (unit_size_e'(size) == SZ_BYTE) begin
            byte_onehot_chk: assert ($countones(need) == 1);
        end
    end

endmodule

// File: rtl/ibp_pair_bank.sv
module ibp_pair_bank
    import ibp_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int VAL_W    = ADDR_W - 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic                              wr_sel,
    input  logic [31:0]                       wr_data,
    output logic [NUM_PAIRS-1:0]              en,
    output logic [NUM_PAIRS-1:0][LANES-1:0]   mask,
    output logic [NUM_PAIRS-1:0][VAL_W-1:0]   val
);

    typedef struct packed {
        logic [NUM_PAIRS-1:0]            en;
        logic [NUM_PAIRS-1:0][LANES-1:0] mask;
        logic [NUM_PAIRS-1:0][VAL_W-1:0] val;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                if (wr_sel) begin
                    bank_d.en[i]   = wr_data[CTRL_EN_BIT];
                    bank_d.mask[i] = wr_data[CTRL_MASK_LSB +: LANES];
                end else begin
                    bank_d.val[i]  = wr_data[ADDR_W-1:2];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign en   = bank_q.en;
    assign mask = bank_q.mask;
    assign val  = bank_q.val;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[4:1], wr_data[1:0]};

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_chk
        // R2
        ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel && wr_idx == IDX_W'(k)) |=>
                (en[k] == $past(wr_data[0]) && mask[k] == $past(wr_data[8:5])));
    end

endmodule

// File: rtl/ibp_pair_match.sv
module ibp_pair_match
    import ibp_pkg::*;
#(
    parameter int VAL_W = 30
) (
    input  logic             en,
    input  logic [VAL_W-1:0] val,
    input  lane_mask_t       mask,
    input  logic [VAL_W-1:0] word_addr,
    input  lane_mask_t       need,
    output logic             hit,
    output logic             part
);

    logic addr_eq;
    logic covers;
    logic touches;

    always_comb begin
        addr_eq = en && (val == word_addr);
        covers  = ((need & ~mask) == '0);
        touches = ((need & mask) != '0);
        hit     = addr_eq && covers;
        part    = addr_eq && touches && !covers;
    end

endmodule

// File: rtl/ibp_comparator.sv
module ibp_comparator
    import ibp_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int VAL_W    = ADDR_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_sel,
    input  logic [31:0]           wr_data,
    input  logic                  ins_valid,
    input  logic [ADDR_W-1:0]     ins_addr,
    input  logic [1:0]            ins_size,
    output logic [NUM_PAIRS-1:0]  hit_vec,
    output logic                  hit_any,
    output logic [NUM_PAIRS-1:0]  part_vec,
    output logic                  part_any
);

    typedef struct packed {
        logic [NUM_PAIRS-1:0] hit_vec;
        logic                 hit_any;
        logic [NUM_PAIRS-1:0] part_vec;
        logic                 part_any;
    } res_t;

    logic [NUM_PAIRS-1:0]            pair_en;
    logic [NUM_PAIRS-1:0][LANES-1:0] pair_mask;
    logic [NUM_PAIRS-1:0][VAL_W-1:0] pair_val;
    lane_mask_t                      need;
    logic [NUM_PAIRS-1:0]            raw_hit;
    logic [NUM_PAIRS-1:0]            raw_part;
    res_t                            res_d, res_q;

    ibp_pair_bank #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .en      (pair_en),
        .mask    (pair_mask),
        .val     (pair_val)
    );

    ibp_lane_decode u_dec (
        .offset (ins_addr[1:0]),
        .size   (ins_size),
        .need   (need)
    );

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        ibp_pair_match #(.VAL_W(VAL_W)) u_match (
            .en        (pair_en[i]),
            .val       (pair_val[i]),
            .mask      (pair_mask[i]),
            .word_addr (ins_addr[ADDR_W-1:2]),
            .need      (need),
            .hit       (raw_hit[i]),
            .part      (raw_part[i])
        );
    end

    always_comb begin
        res_d = '0;
        if (ins_valid) begin
            res_d.hit_vec  = raw_hit;
            res_d.part_vec = raw_part;
            res_d.hit_any  = |raw_hit;
            res_d.part_any = |raw_part;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit_vec  = res_q.hit_vec;
    assign hit_any  = res_q.hit_any;
    assign part_vec = res_q.part_vec;
    assign part_any = res_q.part_any;

    // R6
    hit_part_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & part_vec) == '0);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ins_valid) |-> (hit_vec == '0 && part_vec == '0));

    // R9
    any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any == |hit_vec) && (part_any == |part_vec));

    for (genvar j = 0; j < NUM_PAIRS; j++) begin : g_en_chk
        // R7
        disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_vec[j] || part_vec[j]) |-> $past(pair_en[j]));
    end

endmodule

// File: tb/ibp_comparator_test.sv
module ibp_comparator_test;

    localparam int NP  = 4;
    localparam int AW  = 32;
    localparam int IW  = 2;
    localparam int NV  = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_sel = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_addr = '0;
    logic [1:0]    ins_size = '0;
    logic [NP-1:0] hit_vec, part_vec;
    logic          hit_any, part_any;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    ibp_comparator #(.NUM_PAIRS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_data(wr_data), .ins_valid(ins_valid),
        .ins_addr(ins_addr), .ins_size(ins_size), .hit_vec(hit_vec),
        .hit_any(hit_any), .part_vec(part_vec), .part_any(part_any)
    );

    // {addr, size, expected hit_vec, expected part_vec}
    localparam logic [41:0] VEC [NV] = '{
        {32'h8001, 2'b00, 4'b0001, 4'b0000},  // R5 byte offset 1
        {32'h8000, 2'b00, 4'b0000, 4'b0000},  // R7 no lane overlap
        {32'h8002, 2'b01, 4'b0010, 4'b0000},  // R5 upper half
        {32'h8002, 2'b00, 4'b0010, 4'b0000},  // R3 byte inside mask
        {32'h8000, 2'b01, 4'b0000, 4'b0001},  // R6 partial on byte slot
        {32'h8000, 2'b10, 4'b0000, 4'b0011},  // R6 word over two partial slots
        {32'h8004, 2'b10, 4'b0100, 4'b0000},  // R5 full word
        {32'h8006, 2'b01, 4'b0100, 4'b0000},  // R3 halfword inside word mask
        {32'h8008, 2'b01, 4'b1000, 4'b0000},  // R5 lower half
        {32'h8008, 2'b10, 4'b0000, 4'b1000},  // R6 word over lower-half mask
        {32'h800A, 2'b01, 4'b0000, 4'b0000},  // R7 disjoint lanes
        {32'h9000, 2'b10, 4'b0000, 4'b0000},  // R4 other word
        {32'h8003, 2'b00, 4'b0010, 4'b0000}   // R3 byte offset 3
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input bit sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input bit en, input logic [3:0] m);
        return {23'd0, m, 4'd0, en};
    endfunction

    task automatic run(input logic [31:0] a, input logic [1:0] s,
                       input logic [3:0] eh, input logic [3:0] ep, input string tag);
        @(negedge clk);
        ins_valid = 1'b1; ins_addr = a; ins_size = s;
        @(negedge clk);
        ins_valid = 1'b0;
        chk(tag, {28'd0, hit_vec}, {28'd0, eh});
        chk(tag, {28'd0, part_vec}, {28'd0, ep});
        chk({tag, " R9"}, {30'd0, hit_any, part_any}, {30'd0, |eh, |ep});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {24'd0, hit_vec, part_vec, hit_any, part_any, 2'b00}, 32'd0);
        rst_n = 1'b1;
        run(32'h8000, 2'b10, 4'b0000, 4'b0000, "R1 unprogrammed");

        wr(0, 0, 32'h8000); wr(0, 1, ctl(1, 4'b0010));
        wr(1, 0, 32'h8000); wr(1, 1, ctl(1, 4'b1100));
        wr(2, 0, 32'h8007); wr(2, 1, ctl(1, 4'b1111));  // R2 low bits dropped
        wr(3, 0, 32'h8008); wr(3, 1, ctl(1, 4'b0011));

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][41:10], VEC[i][9:8], VEC[i][7:4], VEC[i][3:0], "R3 R5 R6 R7 table");
        end

        // R8: idle cycle after a hit
        run(32'h8001, 2'b00, 4'b0001, 4'b0000, "R8 pre");
        @(negedge clk);
        chk("R8 idle", {26'd0, hit_vec, hit_any, part_any}, 32'd0);

        // R4: high address bit differs
        run(32'h0001_8002, 2'b01, 4'b0000, 4'b0000, "R4 high bit");

        // R7: disabled slot keeps mask but is silent
        wr(2, 1, ctl(0, 4'b1111));
        run(32'h8004, 2'b10, 4'b0000, 4'b0000, "R7 disabled");

        // R5: 32-bit instruction at halfword offset caught by two slots
        wr(3, 0, 32'h8004); wr(3, 1, ctl(1, 4'b0011));
        run(32'h8002, 2'b01, 4'b0010, 4'b0000, "R5 straddle first");
        run(32'h8004, 2'b01, 4'b1000, 4'b0000, "R5 straddle second");

        // R3: reserved size acts as word
        run(32'h8004, 2'b11, 4'b0000, 4'b1000, "R3 reserved size");

        // R2: write and compare in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'd1; wr_sel = 1'b1; wr_data = ctl(0, 4'b1100);
        ins_valid = 1'b1; ins_addr = 32'h8002; ins_size = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; ins_valid = 1'b0;
        chk("R2 same-cycle old", {28'd0, hit_vec}, 32'h2);
        run(32'h8002, 2'b01, 4'b0000, 4'b0000, "R2 after write");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule